// File: doc/BRIEF.md
# Flash Endurance Error Counter

This engine wears out one flash block on purpose and measures how its bit errors grow. Each iteration erases the block, programs every word of every page with a pseudo-random pattern, then reads all words back. It compares each word against the same pattern, regenerated from the same seed. Every mismatching bit is sorted by the value that was written. It then feeds running direction totals, a total for each page, and separate totals for odd-index and even-index pages.

The flash is reached through a request/acknowledge port that carries one operation at a time: erase block, program word, or read word. A request is held until the device acknowledges it. After every window of consecutive whole iterations, the engine emits the mean error count per iteration for each direction. The window length can be given directly, or it is chosen from the cell type: 200 for one bit per cell, 50 for two bits per cell.

A run starts with a start pulse and a programmed iteration count. It ends with a sticky done flag, or it ends early when abort is raised.

Top module: `flash_wear_counter`

## Requirements
- R1: After reset, busy, done and avg_valid are 0, fl_op is 0 (no request), and every total, every page count and both averages read 0.
- R2: Each iteration issues exactly one erase (fl_op=1), then PAGES*WORDS programs (fl_op=2), then the same number of reads (fl_op=3). Programs and reads both walk the addresses page-major, with the word index incrementing fastest from page 0 word 0. Op, page and word stay unchanged until fl_ack.
- R3: The data programmed in iteration i (counted from 0) begins at seed 0x5EED0000 XOR i. Each programmed word carries the current generator state. After every word the state becomes (s >> 1) XOR (0x80200003 if bit 0 of s is 1, else 0). Read-back compares against the same sequence, restarted from the same seed.
- R4: A bit written 0 and read 1 adds one to plus_tot. A bit written 1 and read 0 adds one to minus_tot.
- R5: pg_err combinationally shows the count for the page selected by pg_sel: plus plus minus errors of all reads from that page since start.
- R6: Errors in pages whose index has bit 0 set add to odd_tot. All other pages add to even_tot.
- R7: After every WIN completed iterations, avg_valid pulses for one cycle. avg_plus and avg_minus then equal the window's summed per-direction errors divided by WIN, rounded down.
- R8: After total_iters iterations, done rises and stays high until the next start. No further flash request is issued. A start with total_iters = 0 goes straight to done.
- R9: An abort while busy lets the outstanding request finish. At that request's fl_ack the engine returns to idle with done low and issues no further request.
- R10: Every counter and every window sum saturates at its all-ones value instead of wrapping.
- R11: A start clears all totals, page counts and window state before the first erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (sampled while idle or done) |
| abort | input | 1 | Stop the run after the outstanding request |
| total_iters | input | ITER_W | Number of iterations in the run |
| fl_ack | input | 1 | Flash has completed the held request |
| fl_rdata | input | 32 | Read data, valid with fl_ack on a read |
| pg_sel | input | log2(PAGES) | Page whose count appears on pg_err |
| fl_op | output | 2 | 0 none, 1 erase, 2 program, 3 read |
| fl_page | output | log2(PAGES) | Page of the request |
| fl_word | output | log2(WORDS) | Word within the page |
| fl_wdata | output | 32 | Program data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed |
| plus_tot | output | CNT_W | 0-to-1 errors |
| minus_tot | output | CNT_W | 1-to-0 errors |
| odd_tot | output | CNT_W | Errors in odd-index pages |
| even_tot | output | CNT_W | Errors in even-index pages |
| pg_err | output | CNT_W | Error count of page pg_sel |
| avg_valid | output | 1 | One-cycle pulse per completed window |
| avg_plus | output | CNT_W | Window mean of 0-to-1 errors |
| avg_minus | output | CNT_W | Window mean of 1-to-0 errors |

## Verification
The first erase request appears one clock after the edge that samples start. A read acknowledged on one edge shows up in the totals and page counts two edges later. avg_valid and done rise on the third edge after the last read of an iteration, so both are visible together. The bench therefore waits for done at a falling edge, waits one more cycle, and only then reads totals and page counts. It captures every avg_valid pulse at the falling edge where it is high. Abort checks wait well past the final acknowledge before they sample busy, done and the model's erase count.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_ERASE = 2'd1,
      OP_PROG  = 2'd2,
      OP_READ  = 2'd3
   } fl_op_e;

   localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;
   localparam logic [31:0] SEED_BASE = 32'h5EED_0000;

   // Galois right-shift step of a maximal-length 32-bit generator
   function automatic logic [31:0] lfsr_next(input logic [31:0] s);
      return (s >> 1) ^ (s[0] ? LFSR_TAPS : 32'h0);
   endfunction

endpackage

// File: rtl/fwc_seq.sv
module fwc_seq
   import fwc_pkg::*;
#(
   parameter int PAGES  = 64,
   parameter int WORDS  = 512,
   parameter int ITER_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          abort,
   input  logic [ITER_W-1:0]             total_iters,
   input  logic                          fl_ack,
   output logic [1:0]                    fl_op,
   output logic [$clog2(PAGES)-1:0]      fl_page,
   output logic [$clog2(WORDS)-1:0]      fl_word,
   output logic [31:0]                   fl_wdata,
   output logic [31:0]                   exp_data,
   output logic                          cmp_fire,
   output logic                          iter_end,
   output logic                          clear,
   output logic                          busy,
   output logic                          done
);
   localparam int PG_W = $clog2(PAGES);
   localparam int WD_W = $clog2(WORDS);
   localparam int AD_W = PG_W + WD_W;

   typedef enum logic [2:0] {
      S_IDLE, S_ERASE, S_PROG, S_READ, S_DRAIN, S_WRAP, S_DONE
   } st_e;

   st_e               st;
   logic [AD_W-1:0]   addr;
   logic [ITER_W-1:0] iter;
   logic [ITER_W-1:0] goal;
   logic [31:0]       lfsr;
   logic              stop_q;
   logic [31:0]       seed;
   logic              halt;
   logic              last_addr;
   logic              resting;
   fl_op_e            op_c;

   assign seed      = SEED_BASE ^ 32'(iter);
   assign halt      = stop_q | abort;
   assign last_addr = &addr;
   assign resting   = (st == S_IDLE) || (st == S_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         addr   <= '0;
         iter   <= '0;
         goal   <= '0;
         lfsr   <= '0;
         stop_q <= 1'b0;
      end else begin
         if (resting)    stop_q <= 1'b0;
         else if (abort) stop_q <= 1'b1;
         unique case (st)
            S_IDLE, S_DONE: begin
               if (start) begin
                  iter <= '0;
                  goal <= total_iters;
                  st   <= (total_iters == '0) ? S_DONE : S_ERASE;
               end
            end
            S_ERASE: begin
               if (fl_ack) begin
                  addr <= '0;
                  lfsr <= seed;
                  st   <= halt ? S_IDLE : S_PROG;
               end
            end
            S_PROG: begin
               if (fl_ack) begin
                  addr <= addr + 1'b1;
                  lfsr <= last_addr ? seed : lfsr_next(lfsr);
                  if (halt)           st <= S_IDLE;
                  else if (last_addr) st <= S_READ;
               end
            end
            S_READ: begin
               if (fl_ack) begin
                  addr <= addr + 1'b1;
                  lfsr <= lfsr_next(lfsr);
                  if (halt)           st <= S_IDLE;
                  else if (last_addr) st <= S_DRAIN;
               end
            end
            S_DRAIN: st <= S_WRAP;
            S_WRAP: begin
               iter <= iter + 1'b1;
               if (halt)                            st <= S_IDLE;
               else if (ITER_W'(iter + 1'b1) == goal) st <= S_DONE;
               else                                 st <= S_ERASE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         S_ERASE: op_c = OP_ERASE;
         S_PROG:  op_c = OP_PROG;
         S_READ:  op_c = OP_READ;
         default: op_c = OP_NONE;
      endcase
   end

   assign fl_op    = op_c;
   assign fl_page  = addr[AD_W-1:WD_W];
   assign fl_word  = addr[WD_W-1:0];
   assign fl_wdata = (st == S_PROG) ? lfsr : 32'h0;
   assign exp_data = lfsr;
   assign cmp_fire = (st == S_READ) && fl_ack;
   assign iter_end = (st == S_WRAP);
   assign clear    = start && resting;
   assign busy     = !resting;
   assign done     = (st == S_DONE);

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_op != OP_NONE && !fl_ack) |=>
         (fl_op == $past(fl_op) && fl_page == $past(fl_page) && fl_word == $past(fl_word)));

   // R2
   erase_then_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_op == OP_ERASE && fl_ack) |=> (fl_op == OP_PROG || fl_op == OP_NONE));

   // R8
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R9
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && fl_ack && fl_op != OP_NONE) |=> (!busy && !done));

endmodule

// File: rtl/fwc_classify.sv
module fwc_classify #(
   parameter int WORD_W = 32,
   parameter int PG_W   = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          fire,
   input  logic [PG_W-1:0]               page,
   input  logic [WORD_W-1:0]             exp_w,
   input  logic [WORD_W-1:0]             got_w,
   output logic                          vld,
   output logic [PG_W-1:0]               page_q,
   output logic [$clog2(WORD_W+1)-1:0]   n_plus,
   output logic [$clog2(WORD_W+1)-1:0]   n_minus
);
   localparam int CW = $clog2(WORD_W + 1);

   function automatic logic [CW-1:0] ones(input logic [WORD_W-1:0] v);
      logic [CW-1:0] n;
      n = '0;
      for (int i = 0; i < WORD_W; i++) n = n + CW'(v[i]);
      return n;
   endfunction

   logic [WORD_W-1:0] flip;
   logic [WORD_W-1:0] up_m;
   logic [WORD_W-1:0] dn_m;

   assign flip = exp_w ^ got_w;
   assign up_m = flip & ~exp_w;   // expected 0, seen 1
   assign dn_m = flip & exp_w;    // expected 1, seen 0

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld     <= 1'b0;
         page_q  <= '0;
         n_plus  <= '0;
         n_minus <= '0;
      end else begin
         vld <= fire;
         if (fire) begin
            page_q  <= page;
            n_plus  <= ones(up_m);
            n_minus <= ones(dn_m);
         end
      end
   end

   // R4
   result_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> $past(fire));

endmodule

// File: rtl/fwc_tally.sv
module fwc_tally #(
   parameter int PAGES = 64,
   parameter int CNT_W = 32,
   parameter int WIN   = 200,
   parameter int CW    = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       in_vld,
   input  logic [$clog2(PAGES)-1:0]   in_page,
   input  logic [CW-1:0]              in_plus,
   input  logic [CW-1:0]              in_minus,
   input  logic                       iter_end,
   input  logic [$clog2(PAGES)-1:0]   pg_sel,
   output logic [CNT_W-1:0]           plus_tot,
   output logic [CNT_W-1:0]           minus_tot,
   output logic [CNT_W-1:0]           odd_tot,
   output logic [CNT_W-1:0]           even_tot,
   output logic [CNT_W-1:0]           pg_err,
   output logic                       avg_valid,
   output logic [CNT_W-1:0]           avg_plus,
   output logic [CNT_W-1:0]           avg_minus
);
   localparam int              PG_W = $clog2(PAGES);
   localparam int              WC_W = $clog2(WIN + 1);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] DIV  = CNT_W'(WIN);

   function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
      logic [CNT_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[CNT_W] ? CMAX : s[CNT_W-1:0];
   endfunction

   logic [CNT_W-1:0] up_x, dn_x, both_x;
   logic [CNT_W-1:0] it_plus, it_minus, win_plus, win_minus;
   logic [CNT_W-1:0] wsum_p, wsum_m;
   logic [WC_W-1:0]  win_cnt;
   logic [PAGES-1:0][CNT_W-1:0] pg_cnt;

   assign up_x   = CNT_W'(in_plus);
   assign dn_x   = CNT_W'(in_minus);
   assign both_x = up_x + dn_x;
   assign wsum_p = sat_add(win_plus, it_plus);
   assign wsum_m = sat_add(win_minus, it_minus);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         plus_tot  <= '0;  minus_tot <= '0;
         odd_tot   <= '0;  even_tot  <= '0;
         it_plus   <= '0;  it_minus  <= '0;
         win_plus  <= '0;  win_minus <= '0;
         win_cnt   <= '0;  avg_valid <= 1'b0;
         avg_plus  <= '0;  avg_minus <= '0;
      end else begin
         avg_valid <= 1'b0;
         if (clear) begin
            plus_tot  <= '0;  minus_tot <= '0;
            odd_tot   <= '0;  even_tot  <= '0;
            it_plus   <= '0;  it_minus  <= '0;
            win_plus  <= '0;  win_minus <= '0;
            win_cnt   <= '0;
            avg_plus  <= '0;  avg_minus <= '0;
         end else begin
            if (in_vld) begin
               plus_tot  <= sat_add(plus_tot, up_x);
               minus_tot <= sat_add(minus_tot, dn_x);
               it_plus   <= sat_add(it_plus, up_x);
               it_minus  <= sat_add(it_minus, dn_x);
               if (in_page[0]) odd_tot  <= sat_add(odd_tot, both_x);
               else            even_tot <= sat_add(even_tot, both_x);
            end
            if (iter_end) begin
               it_plus  <= '0;
               it_minus <= '0;
               if (win_cnt == WC_W'(WIN - 1)) begin
                  avg_plus  <= wsum_p / DIV;
                  avg_minus <= wsum_m / DIV;
                  avg_valid <= 1'b1;
                  win_plus  <= '0;
                  win_minus <= '0;
                  win_cnt   <= '0;
               end else begin
                  win_plus  <= wsum_p;
                  win_minus <= wsum_m;
                  win_cnt   <= WC_W'(win_cnt + 1'b1);
               end
            end
         end
      end
   end

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   cnt_q <= '0;
         else if (clear)                               cnt_q <= '0;
         else if (in_vld && in_page == PG_W'(p))       cnt_q <= sat_add(cnt_q, both_x);
      end
      assign pg_cnt[p] = cnt_q;
   end

   assign pg_err = pg_cnt[pg_sel];

   // R10
   plus_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> plus_tot >= $past(plus_tot));

   // R10
   minus_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> minus_tot >= $past(minus_tot));

   // R6
   odd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !(in_vld && in_page[0])) |=> $stable(odd_tot));

   // R7
   avg_after_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      avg_valid |-> $past(iter_end));

endmodule

// File: rtl/flash_wear_counter.sv
module flash_wear_counter
   import fwc_pkg::*;
#(
   parameter int PAGES       = 64,
   parameter int WORDS       = 512,
   parameter int ITER_W      = 16,
   parameter int CNT_W       = 32,
   parameter int MULTI_LEVEL = 0,
   parameter int WIN_LEN     = 0,
   localparam int PG_W       = $clog2(PAGES),
   localparam int WD_W       = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [ITER_W-1:0] total_iters,
   input  logic              fl_ack,
   input  logic [31:0]       fl_rdata,
   input  logic [PG_W-1:0]   pg_sel,
   output logic [1:0]        fl_op,
   output logic [PG_W-1:0]   fl_page,
   output logic [WD_W-1:0]   fl_word,
   output logic [31:0]       fl_wdata,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  plus_tot,
   output logic [CNT_W-1:0]  minus_tot,
   output logic [CNT_W-1:0]  odd_tot,
   output logic [CNT_W-1:0]  even_tot,
   output logic [CNT_W-1:0]  pg_err,
   output logic              avg_valid,
   output logic [CNT_W-1:0]  avg_plus,
   output logic [CNT_W-1:0]  avg_minus
);
   localparam int WORD_W = 32;
   localparam int CW     = $clog2(WORD_W + 1);
   localparam int WIN    = (WIN_LEN != 0) ? WIN_LEN : ((MULTI_LEVEL != 0) ? 50 : 200);

   initial begin
      assert (PAGES >= 2 && (1 << PG_W) == PAGES) else $fatal(1, "PAGES must be a power of two");
      assert (WORDS >= 2 && (1 << WD_W) == WORDS) else $fatal(1, "WORDS must be a power of two");
      assert (ITER_W >= 1 && ITER_W <= 16) else $fatal(1, "ITER_W out of range");
      assert (CNT_W > CW && CNT_W >= $clog2(WIN + 1)) else $fatal(1, "CNT_W too small");
      assert (WIN >= 1) else $fatal(1, "window must be at least one iteration");
   end

   logic [31:0]     exp_data;
   logic            cmp_fire, iter_end, clear;
   logic            c_vld;
   logic [PG_W-1:0] c_page;
   logic [CW-1:0]   c_plus, c_minus;

   fwc_seq #(.PAGES(PAGES), .WORDS(WORDS), .ITER_W(ITER_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .total_iters(total_iters), .fl_ack(fl_ack),
      .fl_op(fl_op), .fl_page(fl_page), .fl_word(fl_word), .fl_wdata(fl_wdata),
      .exp_data(exp_data), .cmp_fire(cmp_fire), .iter_end(iter_end),
      .clear(clear), .busy(busy), .done(done)
   );

   fwc_classify #(.WORD_W(WORD_W), .PG_W(PG_W)) cls_i (
      .clk(clk), .rst_n(rst_n), .fire(cmp_fire), .page(fl_page),
      .exp_w(exp_data), .got_w(fl_rdata),
      .vld(c_vld), .page_q(c_page), .n_plus(c_plus), .n_minus(c_minus)
   );

   fwc_tally #(.PAGES(PAGES), .CNT_W(CNT_W), .WIN(WIN), .CW(CW)) tally_i (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .in_vld(c_vld), .in_page(c_page), .in_plus(c_plus), .in_minus(c_minus),
      .iter_end(iter_end), .pg_sel(pg_sel),
      .plus_tot(plus_tot), .minus_tot(minus_tot),
      .odd_tot(odd_tot), .even_tot(even_tot), .pg_err(pg_err),
      .avg_valid(avg_valid), .avg_plus(avg_plus), .avg_minus(avg_minus)
   );

endmodule

// File: tb/flash_wear_counter_tb_top.sv
module flash_wear_counter_tb_top;
   localparam int PAGES  = 4;
   localparam int WORDS  = 4;
   localparam int ITER_W = 8;
   localparam int CNT_W  = 8;
   localparam int WIN    = 2;
   localparam int PG_W   = 2;
   localparam int WD_W   = 2;
   localparam int NW     = PAGES * WORDS;
   localparam int SMAX   = 255;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              abort = 1'b0;
   logic [ITER_W-1:0] total_iters = '0;
   logic              fl_ack = 1'b0;
   logic [31:0]       fl_rdata = '0;
   logic [PG_W-1:0]   pg_sel = '0;
   logic [1:0]        fl_op;
   logic [PG_W-1:0]   fl_page;
   logic [WD_W-1:0]   fl_word;
   logic [31:0]       fl_wdata;
   logic              busy, done, avg_valid;
   logic [CNT_W-1:0]  plus_tot, minus_tot, odd_tot, even_tot, pg_err, avg_plus, avg_minus;

   flash_wear_counter #(.PAGES(PAGES), .WORDS(WORDS), .ITER_W(ITER_W),
                        .CNT_W(CNT_W), .WIN_LEN(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .total_iters(total_iters), .fl_ack(fl_ack), .fl_rdata(fl_rdata), .pg_sel(pg_sel),
      .fl_op(fl_op), .fl_page(fl_page), .fl_word(fl_word), .fl_wdata(fl_wdata),
      .busy(busy), .done(done), .plus_tot(plus_tot), .minus_tot(minus_tot),
      .odd_tot(odd_tot), .even_tot(even_tot), .pg_err(pg_err),
      .avg_valid(avg_valid), .avg_plus(avg_plus), .avg_minus(avg_minus)
   );

   int n_chk = 0, n_fail = 0;

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic logic [31:0] gen_step(input logic [31:0] s);
      logic [31:0] r;
      r = {1'b0, s[31:1]};
      if (s[0]) r = r ^ 32'h8020_0003;
      return r;
   endfunction

   function automatic int smin(input int v);
      return (v > SMAX) ? SMAX : v;
   endfunction

   // error injection pattern: 0 none, 1 sparse, 2 whole page 1
   int inj_mode = 0;
   function automatic logic [31:0] mask_of(input int pg, input int wd);
      if (inj_mode == 1) begin
         if (pg == 2 && wd == 1) return 32'h0000_FFFF;
         if (pg == 3 && wd == 0) return 32'hF000_000F;
         return 32'h0;
      end
      if (inj_mode == 2) return (pg == 1) ? 32'hFFFF_FFFF : 32'h0;
      return 32'h0;
   endfunction

   // flash model
   logic [31:0] mem [NW];
   int erase_cnt = 0, wr_bad = 0, ord_bad = 0, lat = 0, phase = 0, exp_addr = 0;
   logic [31:0] m_lfsr = '0;

   always @(negedge clk) begin
      if (fl_ack) fl_ack = 1'b0;
      else if (fl_op != 2'd0) begin
         if (lat < 1) lat++;
         else begin
            int idx;
            lat = 0;
            idx = int'(fl_page) * WORDS + int'(fl_word);
            case (fl_op)
               2'd1: begin
                  if (phase == 1 || phase == 2) ord_bad++;
                  for (int i = 0; i < NW; i++) mem[i] = 32'hFFFF_FFFF;
                  m_lfsr = 32'h5EED_0000 ^ 32'(erase_cnt);
                  erase_cnt++;
                  phase = 1; exp_addr = 0;
               end
               2'd2: begin
                  if (phase != 1 || idx != exp_addr) ord_bad++;
                  if (fl_wdata !== m_lfsr) wr_bad++;
                  mem[idx] = mem[idx] & fl_wdata;
                  m_lfsr = gen_step(m_lfsr);
                  exp_addr++;
                  if (exp_addr == NW) begin phase = 2; exp_addr = 0; end
               end
               default: begin
                  if (phase != 2 || idx != exp_addr) ord_bad++;
                  fl_rdata = mem[idx] ^ mask_of(int'(fl_page), int'(fl_word));
                  exp_addr++;
                  if (exp_addr == NW) phase = 3;
               end
            endcase
            fl_ack = 1'b1;
         end
      end else lat = 0;
   end

   // average capture
   int n_av = 0;
   logic [CNT_W-1:0] av_p [16];
   logic [CNT_W-1:0] av_m [16];
   always @(negedge clk) begin
      if (avg_valid && n_av < 16) begin
         av_p[n_av] = avg_plus;
         av_m[n_av] = avg_minus;
         n_av++;
      end
   end

   // expected values from the requirements
   int e_plus, e_minus, e_odd, e_even;
   int e_pg [PAGES];
   int e_itp [16];
   int e_itm [16];

   task automatic calc(input int iters);
      e_plus = 0; e_minus = 0; e_odd = 0; e_even = 0;
      for (int p = 0; p < PAGES; p++) e_pg[p] = 0;
      for (int it = 0; it < iters; it++) begin
         logic [31:0] s;
         s = 32'h5EED_0000 ^ 32'(it);
         e_itp[it] = 0; e_itm[it] = 0;
         for (int a = 0; a < NW; a++) begin
            logic [31:0] m;
            int up, dn;
            m  = mask_of(a / WORDS, a % WORDS);
            up = $countones(m & ~s);
            dn = $countones(m & s);
            e_itp[it] += up; e_itm[it] += dn;
            e_plus += up; e_minus += dn;
            e_pg[a / WORDS] += up + dn;
            if (((a / WORDS) % 2) == 1) e_odd += up + dn;
            else                        e_even += up + dn;
            s = gen_step(s);
         end
      end
   endtask

   task automatic run(input int iters);
      erase_cnt = 0; phase = 0; exp_addr = 0; n_av = 0; wr_bad = 0; ord_bad = 0;
      @(negedge clk);
      start = 1'b1;
      total_iters = ITER_W'(iters);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 20000 && !done; k++) @(negedge clk);
      check("R8 done raised at end of run", 32'(done), 1);
      @(negedge clk);
   endtask

   task automatic chk_page(input int p, input int exp, input string tag);
      @(negedge clk);
      pg_sel = PG_W'(p);
      #1;
      check(tag, 32'(pg_err), 32'(exp));
   endtask

   task automatic t_reset;
      check("R1 busy after reset", 32'(busy), 0);
      check("R1 done after reset", 32'(done), 0);
      check("R1 no request after reset", 32'(fl_op), 0);
      check("R1 plus_tot after reset", 32'(plus_tot), 0);
      check("R1 minus_tot after reset", 32'(minus_tot), 0);
      check("R1 odd_tot after reset", 32'(odd_tot), 0);
      check("R1 avg_valid after reset", 32'(avg_valid), 0);
      chk_page(3, 0, "R1 page count after reset");
   endtask

   task automatic t_clean;
      inj_mode = 0;
      run(3);
      check("R2 command order", 32'(ord_bad), 0);
      check("R3 programmed pattern", 32'(wr_bad), 0);
      check("R8 erase count equals iterations", 32'(erase_cnt), 3);
      check("R4 plus_tot clean", 32'(plus_tot), 0);
      check("R4 minus_tot clean", 32'(minus_tot), 0);
      check("R7 one window in three iterations", 32'(n_av), 1);
      check("R7 clean window mean", 32'(av_p[0]), 0);
      repeat (20) @(negedge clk);
      check("R8 no request after done", 32'(fl_op), 0);
      check("R8 no further erase after done", 32'(erase_cnt), 3);
      check("R8 done held", 32'(done), 1);
   endtask

   task automatic t_dir;
      inj_mode = 1;
      calc(4);
      run(4);
      check("R2 order with errors", 32'(ord_bad), 0);
      check("R4 plus_tot", 32'(plus_tot), 32'(smin(e_plus)));
      check("R4 minus_tot", 32'(minus_tot), 32'(smin(e_minus)));
      check("R6 odd_tot", 32'(odd_tot), 32'(smin(e_odd)));
      check("R6 even_tot", 32'(even_tot), 32'(smin(e_even)));
      for (int p = 0; p < PAGES; p++) chk_page(p, smin(e_pg[p]), "R5 page count");
      check("R7 window count", 32'(n_av), 2);
      for (int w = 0; w < 2; w++) begin
         check("R7 window mean plus", 32'(av_p[w]), 32'(smin(e_itp[2*w] + e_itp[2*w+1]) / WIN));
         check("R7 window mean minus", 32'(av_m[w]), 32'(smin(e_itm[2*w] + e_itm[2*w+1]) / WIN));
      end
   endtask

   task automatic t_sat;
      inj_mode = 2;
      calc(5);
      run(5);
      check("R10 plus_tot saturates", 32'(plus_tot), 32'(smin(e_plus)));
      check("R10 minus_tot saturates", 32'(minus_tot), 32'(smin(e_minus)));
      check("R10 odd_tot saturates", 32'(odd_tot), SMAX);
      check("R6 even_tot with odd-only errors", 32'(even_tot), 0);
      chk_page(1, SMAX, "R10 page count saturates");
      check("R7 windows in five iterations", 32'(n_av), 2);
      check("R7 heavy window mean", 32'(av_p[1]), 32'(smin(e_itp[2] + e_itp[3]) / WIN));
   endtask

   task automatic t_abort;
      int seen;
      inj_mode = 0;
      erase_cnt = 0; phase = 0; exp_addr = 0; ord_bad = 0;
      @(negedge clk);
      start = 1'b1;
      total_iters = ITER_W'(20);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 2000 && fl_op != 2'd3; k++) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      repeat (30) @(negedge clk);
      seen = erase_cnt;
      check("R9 idle after abort", 32'(busy), 0);
      check("R9 done low after abort", 32'(done), 0);
      check("R9 no request after abort", 32'(fl_op), 0);
      check("R9 no erase after abort", 32'(seen), 1);
      check("R9 order kept up to abort", 32'(ord_bad), 0);
   endtask

   task automatic t_restart;
      inj_mode = 2;
      run(1);
      inj_mode = 0;
      run(1);
      check("R11 plus_tot cleared by start", 32'(plus_tot), 0);
      check("R11 odd_tot cleared by start", 32'(odd_tot), 0);
      chk_page(1, 0, "R11 page count cleared by start");
      check("R11 no window after one iteration", 32'(n_av), 0);
      @(negedge clk);
      start = 1'b1;
      total_iters = '0;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R8 zero iterations go straight to done", 32'(done), 1);
      check("R8 zero iterations issue no request", 32'(fl_op), 0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_dir();
      t_sat();
      t_abort();
      t_restart();
      summary();
      $finish;
   end

endmodule